// File: doc/BRIEF.md
# Response Ring Writer with Interrupt Coalescing

This block sits on the controller side of an audio codec link. Responses come in from the link through a valid/ready handshake. Each accepted response is written as one 8-byte entry into a circular ring in system memory. The ring's base address, its size, a run control and the interrupt settings are held in a small word-addressed register file. A hardware write pointer tells software which entry was filled last.

Software reports how far it has read through a read-pointer input. A response that would land on the entry software has not yet consumed is dropped rather than written. The drop sets a sticky overrun flag, which can raise an interrupt. Response interrupts are coalesced: the status flag is set only after a programmable number of entries has been written.

The register file uses word addresses. 0 holds base low, with bits 6:0 forced to zero. 1 holds base high. 2 is the write pointer. 3 is the interrupt count. 4 is control: bit 0 enables the response interrupt, bit 1 is run and bit 2 enables the overrun interrupt. 5 is status: bit 0 is the response flag and bit 2 is the overrun flag. 6 is size.

Top module: `resp_ring_writer`

## Requirements
- R1: Each entry is written to base + 8 × index. The base has bits 6:0 forced to zero. mem_wr_data[31:0] carries the response word, [35:32] the codec address and [36] the unsolicited flag; bits 63:37 are zero.
- R2: The write pointer register (address 2) reads the index of the last entry written in bits 7:0. After a reset it is 0, so the first response goes to entry 1. Each write advances it by one, wrapping at the ring size.
- R3: Writing a 1 to bit 15 of the write pointer register returns the pointer to 0 and clears the coalescing counter. Bit 15 always reads as 0.
- R4: While control bit 1 (run) is 0, no memory write is issued and rsp_ready stays low.
- R5: If the next index equals sw_rdptr, the response is consumed (rsp_ready high) but not written, the pointer is unchanged and status bit 2 is set.
- R6: Status bit 2 stays set until a 1 is written to it. irq follows it only while control bit 2 is 1.
- R7: Status bit 0 is set when the count of written entries reaches the value in register 3, where 0 means 256. The counter then restarts. The bit is cleared by writing a 1 to it, and irq follows it only while control bit 0 is 1.
- R8: The size register (address 6) holds the ring code in bits 1:0: 00 is 2 entries, 01 is 16 and 10 is 256. Bits 6:4 read the fixed capability mask. A write of code 11 leaves the size unchanged.
- R9: Base low (address 0) reads back with bits 6:0 as zero.
- R10: After reset the pointer, control, status, count and size code are all 0, and irq is low.
- R11: While mem_wr_ready is low, a response that would be written is held (rsp_ready low) and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sw_rdptr | input | 8 | Index of last entry consumed by software |
| rsp_valid | input | 1 | Response available |
| rsp_ready | output | 1 | Response consumed this cycle |
| rsp_word | input | 32 | Response payload |
| rsp_codec | input | 4 | Codec address of the response |
| rsp_unsol | input | 1 | Unsolicited response flag |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 64 | Byte address of the entry |
| mem_wr_data | output | 64 | Entry contents |
| irq | output | 1 | Interrupt request |

## Verification
The memory write request, its address and data, and rsp_ready are combinational from the response inputs and the current pointer. They are sampled in the same cycle the response is driven. The pointer, both status flags and irq change on the clock edge that completes a handshake or a register write. They are checked at the falling edge that follows. Register reads are combinational, so each read is sampled one time unit after the address is set. Inputs always change at falling edges, which keeps every sample clear of the active edge.

// File: rtl/rring_pkg.sv
package rring_pkg;
  localparam int REG_AW   = 3;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 8;
  localparam int CODEC_W  = 4;
  localparam int ENTRY_W  = 64;
  localparam int MADDR_W  = 64;
  localparam int ALIGN_W  = 7;
  localparam int ENTRY_SH = 3;
  localparam int CNT_W    = IDX_W + 1;

  typedef enum logic [REG_AW-1:0] {
    RA_BASE_LO = 3'd0,
    RA_BASE_HI = 3'd1,
    RA_WPTR    = 3'd2,
    RA_ICNT    = 3'd3,
    RA_CTRL    = 3'd4,
    RA_STAT    = 3'd5,
    RA_SIZE    = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    SZ_2    = 2'b00,
    SZ_16   = 2'b01,
    SZ_256  = 2'b10,
    SZ_RSVD = 2'b11
  } ring_size_e;

  localparam int WPRST_BIT = 15;
  localparam int CTRL_RIEN = 0;
  localparam int CTRL_RUN  = 1;
  localparam int CTRL_OIEN = 2;
  localparam int STAT_RSP  = 0;
  localparam int STAT_OVR  = 2;

  function automatic logic [IDX_W-1:0] idx_mask(ring_size_e s);
    case (s)
      SZ_2:    idx_mask = IDX_W'(1);
      SZ_16:   idx_mask = IDX_W'(15);
      default: idx_mask = {IDX_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/rring_regs.sv
module rring_regs
  import rring_pkg::*;
#(
  parameter logic [2:0] CAP_BITS = 3'b111
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [IDX_W-1:0]    wp,
  input  logic                resp_hit,
  input  logic                ovr_hit,
  output logic [MADDR_W-1:0]  base_addr,
  output logic                run,
  output logic                rien,
  output logic                oien,
  output logic [IDX_W-1:0]    icnt,
  output ring_size_e          size_code,
  output logic                wp_rst,
  output logic                resp_sts,
  output logic                ovr_sts
);
  localparam int BLO_W = DATA_W - ALIGN_W;

  logic [BLO_W-1:0]  blo_q, blo_d;
  logic [DATA_W-1:0] bhi_q, bhi_d;
  logic [IDX_W-1:0]  icnt_q, icnt_d;
  logic [2:0]        ctrl_q, ctrl_d;
  logic              rsts_q, rsts_d, osts_q, osts_d;
  ring_size_e        size_q, size_d;
  logic              wr_blo, wr_bhi, wr_icnt, wr_ctrl, wr_stat, wr_size;

  always_comb begin
    wr_blo  = reg_wr && (reg_addr == RA_BASE_LO);
    wr_bhi  = reg_wr && (reg_addr == RA_BASE_HI);
    wr_icnt = reg_wr && (reg_addr == RA_ICNT);
    wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    wr_stat = reg_wr && (reg_addr == RA_STAT);
    wr_size = reg_wr && (reg_addr == RA_SIZE) &&
              (ring_size_e'(reg_wdata[1:0]) != SZ_RSVD);
    wp_rst  = reg_wr && (reg_addr == RA_WPTR) && reg_wdata[WPRST_BIT];

    blo_d  = reg_wdata[DATA_W-1:ALIGN_W];
    bhi_d  = reg_wdata;
    icnt_d = reg_wdata[IDX_W-1:0];
    ctrl_d = reg_wdata[2:0];
    size_d = ring_size_e'(reg_wdata[1:0]);

    rsts_d = rsts_q;
    if (wr_stat && reg_wdata[STAT_RSP]) rsts_d = 1'b0;
    if (resp_hit) rsts_d = 1'b1;
    osts_d = osts_q;
    if (wr_stat && reg_wdata[STAT_OVR]) osts_d = 1'b0;
    if (ovr_hit) osts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blo_q  <= '0;
      bhi_q  <= '0;
      icnt_q <= '0;
      ctrl_q <= '0;
      rsts_q <= 1'b0;
      osts_q <= 1'b0;
      size_q <= SZ_2;
    end else begin
      if (wr_blo)  blo_q  <= blo_d;
      if (wr_bhi)  bhi_q  <= bhi_d;
      if (wr_icnt) icnt_q <= icnt_d;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_size) size_q <= size_d;
      rsts_q <= rsts_d;
      osts_q <= osts_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_BASE_LO: reg_rdata = {blo_q, {ALIGN_W{1'b0}}};
      RA_BASE_HI: reg_rdata = bhi_q;
      RA_WPTR:    reg_rdata = {{(DATA_W-IDX_W){1'b0}}, wp};
      RA_ICNT:    reg_rdata = {{(DATA_W-IDX_W){1'b0}}, icnt_q};
      RA_CTRL:    reg_rdata = {{(DATA_W-3){1'b0}}, ctrl_q};
      RA_STAT:    reg_rdata = {{(DATA_W-3){1'b0}}, osts_q, 1'b0, rsts_q};
      RA_SIZE:    reg_rdata = {{(DATA_W-7){1'b0}}, CAP_BITS, 2'b00, size_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign base_addr = {bhi_q, blo_q, {ALIGN_W{1'b0}}};
  assign run       = ctrl_q[CTRL_RUN];
  assign rien      = ctrl_q[CTRL_RIEN];
  assign oien      = ctrl_q[CTRL_OIEN];
  assign icnt      = icnt_q;
  assign size_code = size_q;
  assign resp_sts  = rsts_q;
  assign ovr_sts   = osts_q;

  // R6: overrun flag holds until software clears it
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (osts_q && !(wr_stat && reg_wdata[STAT_OVR])) |=> osts_q);
endmodule

// File: rtl/rring_ptr.sv
module rring_ptr
  import rring_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  ring_size_e          size_code,
  input  logic [IDX_W-1:0]    sw_rdptr,
  input  logic [MADDR_W-1:0]  base_addr,
  input  logic                wp_rst,
  input  logic                rsp_valid,
  input  logic [DATA_W-1:0]   rsp_word,
  input  logic [CODEC_W-1:0]  rsp_codec,
  input  logic                rsp_unsol,
  output logic                rsp_ready,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [MADDR_W-1:0]  mem_wr_addr,
  output logic [ENTRY_W-1:0]  mem_wr_data,
  output logic [IDX_W-1:0]    wp,
  output logic                wr_fire,
  output logic                ovr_hit
);
  localparam int PAD_W = ENTRY_W - DATA_W - CODEC_W - 1;

  logic [IDX_W-1:0] wp_q, wp_d, nxt, mask;
  logic             full;

  always_comb begin
    mask         = idx_mask(size_code);
    nxt          = (wp_q + IDX_W'(1)) & mask;
    full         = (nxt == sw_rdptr);
    mem_wr_valid = run && rsp_valid && !full;
    ovr_hit      = run && rsp_valid && full;
    rsp_ready    = run && (full || mem_wr_ready);
    wr_fire      = mem_wr_valid && mem_wr_ready;
    mem_wr_addr  = base_addr + {{(MADDR_W-IDX_W-ENTRY_SH){1'b0}}, nxt, {ENTRY_SH{1'b0}}};
    mem_wr_data  = {{PAD_W{1'b0}}, rsp_unsol, rsp_codec, rsp_word};
    wp_d         = wp_q;
    if (wr_fire) wp_d = nxt;
    if (wp_rst)  wp_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  assign wp = wp_q;

  // R2: pointer moves only on a completed write or a reset request
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !wp_rst) |=> $stable(wp_q));
  // R3: reset request returns the pointer to zero
  a_r3_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wp_rst |=> (wp_q == '0));
endmodule

// File: rtl/rring_coalesce.sv
module rring_coalesce
  import rring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             wp_rst,
  input  logic [IDX_W-1:0] icnt,
  output logic             resp_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, thr, cnt_inc;

  always_comb begin
    thr      = (icnt == '0) ? CNT_W'(1 << IDX_W) : {1'b0, icnt};
    cnt_inc  = cnt_q + CNT_W'(1);
    resp_hit = wr_fire && (cnt_inc == thr);
    cnt_d    = cnt_q;
    if (wr_fire) cnt_d = resp_hit ? '0 : cnt_inc;
    if (wp_rst)  cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rring_pkg::*;
#(
  parameter logic [2:0] CAP_BITS = 3'b111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic [7:0]   sw_rdptr,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [31:0]  rsp_word,
  input  logic [3:0]   rsp_codec,
  input  logic         rsp_unsol,
  output logic         mem_wr_valid,
  input  logic         mem_wr_ready,
  output logic [63:0]  mem_wr_addr,
  output logic [63:0]  mem_wr_data,
  output logic         irq
);
  logic [MADDR_W-1:0] base_addr;
  logic               run, rien, oien, wp_rst, resp_sts, ovr_sts;
  logic               resp_hit, ovr_hit, wr_fire;
  logic [IDX_W-1:0]   icnt, wp;
  ring_size_e         size_code;

  rring_regs #(.CAP_BITS(CAP_BITS)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .wp, .resp_hit, .ovr_hit, .base_addr, .run, .rien, .oien,
    .icnt, .size_code, .wp_rst, .resp_sts, .ovr_sts
  );

  rring_ptr ptr_i (
    .clk, .rst_n, .run, .size_code, .sw_rdptr, .base_addr, .wp_rst,
    .rsp_valid, .rsp_word, .rsp_codec, .rsp_unsol, .rsp_ready,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data,
    .wp, .wr_fire, .ovr_hit
  );

  rring_coalesce coal_i (
    .clk, .rst_n, .wr_fire, .wp_rst, .icnt, .resp_hit
  );

  assign irq = (resp_sts && rien) || (ovr_sts && oien);

  // R4: a stopped ring neither writes nor consumes
  a_r4_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!mem_wr_valid && !rsp_ready));
  // R7: reaching the count raises the response flag
  a_r7_count_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |=> resp_sts);
endmodule

// File: tb/resp_ring_writer_tb_top.sv
module resp_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_00AB_1234_5680;
  localparam logic [36:0] VECS [0:5] = '{
    {32'hDEAD_BEEF, 4'h0, 1'b0},
    {32'h0000_0001, 4'h3, 1'b1},
    {32'h8000_0000, 4'hF, 1'b0},
    {32'h1234_5678, 4'h1, 1'b1},
    {32'hFFFF_FFFF, 4'h7, 1'b0},
    {32'h0F0F_A5A5, 4'hA, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] sw_rdptr = '0;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_word = '0;
  logic [3:0] rsp_codec = '0;
  logic rsp_unsol = 1'b0;
  logic mem_wr_valid, mem_wr_ready = 1'b1;
  logic [63:0] mem_wr_addr, mem_wr_data;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_ring_writer dut_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .sw_rdptr,
    .rsp_valid, .rsp_ready, .rsp_word, .rsp_codec, .rsp_unsol,
    .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data, .irq
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  logic s_v, s_r;
  logic [63:0] s_a, s_d;
  task automatic send(input logic [36:0] vec);
    rsp_valid = 1'b1; {rsp_word, rsp_codec, rsp_unsol} = vec;
    #1; s_v = mem_wr_valid; s_r = rsp_ready; s_a = mem_wr_addr; s_d = mem_wr_data;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic logic [63:0] ent(input logic [36:0] vec);
    return {27'b0, vec[0], vec[4:1], vec[36:5]};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    rd_reg(3'd2, rd); chk("R10 wptr", rd, 0);
    rd_reg(3'd4, rd); chk("R10 ctrl", rd, 0);
    rd_reg(3'd5, rd); chk("R10 stat", rd, 0);
    rd_reg(3'd3, rd); chk("R10 icnt", rd, 0);
    rd_reg(3'd6, rd); chk("R10/R8 size", rd, 32'h70);
    chk("R10 irq", irq, 0);
    // R4: stopped ring
    send({32'h5, 4'h1, 1'b0});
    chk("R4 no write", s_v, 0); chk("R4 not ready", s_r, 0);
    rd_reg(3'd2, rd); chk("R4 wptr", rd, 0);
    // setup
    wr_reg(3'd0, 32'h1234_56FF);
    wr_reg(3'd1, 32'h0000_00AB);
    rd_reg(3'd0, rd); chk("R9 base lo", rd, 32'h1234_5680);
    wr_reg(3'd6, 32'h1);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd4, 32'h7);
    // R1/R2/R7: vector walk
    for (int i = 0; i < 6; i++) begin
      send(VECS[i]);
      chk("R1 valid", s_v, 1);
      chk("R1 addr", s_a, BASE + 64'(8 * (i + 1)));
      chk("R1 data", s_d, ent(VECS[i]));
      rd_reg(3'd2, rd); chk("R2 wptr", rd, 32'(i + 1));
      chk("R7 irq", irq, (i == 2 || i == 5));
      if (irq) begin
        rd_reg(3'd5, rd); chk("R7 stat", rd, 32'h1);
        wr_reg(3'd5, 32'h1);
        chk("R7 clear", irq, 0);
      end
    end
    // R2 wrap in 16-entry ring
    wr_reg(3'd3, 32'd0);
    sw_rdptr = 8'd3;
    for (int i = 7; i < 16; i++) send(VECS[i % 6]);
    rd_reg(3'd2, rd); chk("R2 at 15", rd, 15);
    send(VECS[1]);
    chk("R2 wrap addr", s_a, BASE);
    rd_reg(3'd2, rd); chk("R2 wrap wptr", rd, 0);
    send(VECS[2]); send(VECS[3]);
    // R5: full
    send(VECS[4]);
    chk("R5 no write", s_v, 0); chk("R5 consumed", s_r, 1);
    rd_reg(3'd2, rd); chk("R5 wptr", rd, 2);
    rd_reg(3'd5, rd); chk("R5 stat", rd, 32'h4);
    chk("R6 irq", irq, 1);
    @(negedge clk);
    rd_reg(3'd5, rd); chk("R6 sticky", rd, 32'h4);
    wr_reg(3'd5, 32'h4);
    rd_reg(3'd5, rd); chk("R6 cleared", rd, 0);
    chk("R6 irq off", irq, 0);
    wr_reg(3'd4, 32'h3);
    send(VECS[4]);
    rd_reg(3'd5, rd); chk("R6 stat masked", rd, 32'h4);
    chk("R6 irq masked", irq, 0);
    wr_reg(3'd5, 32'h4);
    wr_reg(3'd4, 32'h7);
    // R11: backpressure
    sw_rdptr = 8'd0;
    mem_wr_ready = 1'b0;
    send(VECS[0]);
    chk("R11 valid", s_v, 1); chk("R11 not ready", s_r, 0);
    rd_reg(3'd2, rd); chk("R11 wptr", rd, 2);
    mem_wr_ready = 1'b1;
    // R3: pointer reset
    wr_reg(3'd2, 32'h8000);
    rd_reg(3'd2, rd); chk("R3 wptr", rd, 0);
    wr_reg(3'd3, 32'd2);
    send(VECS[5]);
    chk("R3 first addr", s_a, BASE + 64'd8);
    chk("R3 no irq yet", irq, 0);
    send(VECS[0]);
    chk("R3/R7 count restarted", irq, 1);
    wr_reg(3'd5, 32'h1);
    // R8: size register
    wr_reg(3'd6, 32'h3);
    rd_reg(3'd6, rd); chk("R8 reserved ignored", rd, 32'h71);
    wr_reg(3'd6, 32'h0);
    rd_reg(3'd6, rd); chk("R8 size 2", rd, 32'h70);
    wr_reg(3'd2, 32'h8000);
    send(VECS[1]);
    chk("R8 two-entry addr", s_a, BASE + 64'd8);
    send(VECS[2]);
    chk("R8 two-entry full", s_v, 0);
    wr_reg(3'd5, 32'h4);
    sw_rdptr = 8'd1;
    send(VECS[3]);
    chk("R8 two-entry wrap", s_a, BASE);
    rd_reg(3'd2, rd); chk("R8 wptr", rd, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule